// File: doc/BRIEF.md
# Memory-Mapped Instruction Cache Array Access Port

This block is a slave on a simple register bus. It lets software inspect and modify the tag array and the data array of a direct-mapped instruction cache. Each bus access is a 32-bit longword. The top address byte picks the region: one code selects the tag/valid array and another selects the line data. Address bits [12:5] pick the cache entry in either region.

A tag-array write has two forms. A plain write stores a tag and a valid bit. An associative write compares the stored tag with the tag carried in the write data. It changes the valid bit only on a match against a valid entry, which is how software invalidates a single line by address. When translation is enabled, the tag in the write data is first sent through an external lookup handshake and the physical tag that comes back is compared instead. A lookup miss turns the write into a no-op. A multiple-hit result raises a one-cycle fault output and writes nothing.

The master holds `busValid` and its address, data and size steady until it sees `busReady`, and then lowers `busValid`.

Top module: `icArrayPort`

## Requirements
- R1: After reset `busReady`, `xlatReq`, `faultMultiHit` and `errSticky` are 0, and every tag-array entry reads back as 0 (tag 0, valid 0).
- R2: Address bits [31:24] = 0xF0 select the tag array and 0xF1 select the data array. Any other value reads 0 and writes change nothing.
- R3: The entry index is address bits [12:5] in both regions. Address bits [23:13] do not take part in the index.
- R4: In the data region, address bits [4:2] select one of the 8 longwords of the line. A write stores `busWdata` there, and a read returns it.
- R5: A tag-array read returns the tag in bits [31:10], the valid bit in bit 0 and 0 in bits [9:1]. Write-data bits [9:1] are discarded.
- R6: A tag-array write with association bit (address bit 3) = 0 stores write-data bits [31:10] as the tag and bit 0 as the valid bit, unconditionally.
- R7: With translation disabled, a tag-array write with address bit 3 = 1 writes data bit 0 into the valid bit only if the stored valid bit is 1 and the stored tag equals data bits [31:10]. Otherwise the entry is unchanged.
- R8: With translation enabled, that associative write raises `xlatReq` with `xlatVtag` = data bits [31:10] and holds it until `xlatAck`. On a hit, `xlatPtag` is the tag compared. On a miss the entry is unchanged. `busReady` follows in the cycle after `xlatAck`.
- R9: An acknowledge with `xlatMulti` = 1 leaves the entry unchanged and drives `faultMultiHit` high for exactly the `busReady` cycle.
- R10: An access whose `busSize` is not longword (code 2'b10; 2'b00 is byte, 2'b01 is word) or whose address bits [1:0] are nonzero changes no state and sets `errSticky`. `errSticky` stays set until reset, and the access still completes with `busReady`.
- R11: An access that needs no lookup raises `busReady` for one cycle, in the cycle after the accepting clock edge. A read's data is valid on `busRdata` in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Access request, held until busReady |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 32 | Access address |
| busSize | input | 2 | 00 byte, 01 word, 10 longword |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while busReady |
| busReady | output | 1 | One-cycle completion strobe |
| xlatEnable | input | 1 | Translate the tag of associative writes |
| xlatReq | output | 1 | Lookup request |
| xlatVtag | output | 22 | Tag to be translated |
| xlatAck | input | 1 | Lookup done |
| xlatHit | input | 1 | Lookup found one match |
| xlatMiss | input | 1 | Lookup found no match |
| xlatMulti | input | 1 | Lookup found several matches |
| xlatPtag | input | 22 | Translated tag, valid with xlatAck and xlatHit |
| faultMultiHit | output | 1 | Multiple-hit fault pulse |
| errSticky | output | 1 | Illegal-access flag, cleared by reset |

## Verification
A read or write that needs no lookup completes one clock after it is accepted. The bench drives inputs on falling edges and expects `busReady` and the read data at the very next falling edge, so it measures a latency of exactly 1. A translated associative write completes one cycle after the acknowledge. The bench's lookup responder acknowledges a fixed number of cycles after it sees `xlatReq`, so the bench knows the exact latency, and it samples `faultMultiHit` in the same falling-edge window as `busReady`. Every write is verified by a later read through the bus, sampled in that read's ready cycle.

// File: rtl/icArrayPortPkg.sv
package icArrayPortPkg;

  localparam logic [7:0] REGION_TAG  = 8'hF0;
  localparam logic [7:0] REGION_DATA = 8'hF1;
  localparam logic [1:0] SIZE_LONG   = 2'b10;
  localparam int         ASSOC_BIT   = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XLAT = 2'd1,
    ST_RESP = 2'd2
  } ctrlState_e;

  typedef struct packed {
    logic capRead;
    logic tagWrPlain;
    logic tagWrAssoc;
    logic dataWr;
    logic usePhys;
  } dpStrobe_t;

endpackage

// File: rtl/icArrayPortCtrl.sv
module icArrayPortCtrl
  import icArrayPortPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      busValid,
  input  logic      busWrite,
  input  logic [31:0] busAddr,
  input  logic [1:0] busSize,
  input  logic      xlatEnable,
  input  logic      xlatAck,
  input  logic      xlatHit,
  input  logic      xlatMiss,
  input  logic      xlatMulti,
  output dpStrobe_t strobe,
  output logic      busReady,
  output logic      xlatReq,
  output logic      faultMultiHit,
  output logic      errSticky
);

  ctrlState_e state, stateNext;
  logic illegal, isTag, isData, assocBit, accept, needXlat, ackHit, ackMulti;

  assign illegal  = (busSize != SIZE_LONG) || (busAddr[1:0] != 2'b00);
  assign isTag    = busAddr[31:24] == REGION_TAG;
  assign isData   = busAddr[31:24] == REGION_DATA;
  assign assocBit = busAddr[ASSOC_BIT];
  assign accept   = (state == ST_IDLE) && busValid && !illegal;
  assign needXlat = accept && busWrite && isTag && assocBit && xlatEnable;
  assign ackMulti = (state == ST_XLAT) && xlatAck && xlatMulti;
  // A miss, or an ack with no flag, leaves the entry alone.
  assign ackHit   = (state == ST_XLAT) && xlatAck && xlatHit && !xlatMulti && !xlatMiss;

  always_comb begin
    strobe            = '0;
    strobe.capRead    = accept && !busWrite;
    strobe.dataWr     = accept && busWrite && isData;
    strobe.tagWrPlain = accept && busWrite && isTag && !assocBit;
    strobe.tagWrAssoc = (accept && busWrite && isTag && assocBit && !xlatEnable) || ackHit;
    strobe.usePhys    = ackHit;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (busValid) stateNext = needXlat ? ST_XLAT : ST_RESP;
      ST_XLAT: if (xlatAck) stateNext = ST_RESP;
      ST_RESP: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      errSticky     <= 1'b0;
      faultMultiHit <= 1'b0;
    end else begin
      state         <= stateNext;
      faultMultiHit <= ackMulti;
      if ((state == ST_IDLE) && busValid && illegal) errSticky <= 1'b1;
    end
  end

  assign busReady = state == ST_RESP;
  assign xlatReq  = state == ST_XLAT;

endmodule

// File: rtl/icArrayPortDatapath.sv
module icArrayPortDatapath
  import icArrayPortPkg::*;
#(
  parameter int INDEX_BITS = 8,
  parameter int WORDS      = 8,
  parameter int TAG_BITS   = 22
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [31:0]         busAddr,
  input  logic [31:0]         busWdata,
  input  logic [TAG_BITS-1:0] xlatPtag,
  output logic [31:0]         busRdata
);

  localparam int WORD_BITS = $clog2(WORDS);
  localparam int INDEX_LSB = 2 + WORD_BITS;
  localparam int ENTRIES   = 1 << INDEX_BITS;
  localparam int TAG_LSB   = 32 - TAG_BITS;
  localparam int SLOTS     = ENTRIES * WORDS;

  logic [TAG_BITS-1:0] tagMem  [ENTRIES];
  logic [ENTRIES-1:0]  validMem;
  logic [31:0]         dataMem [SLOTS];

  logic [INDEX_BITS-1:0]            idx;
  logic [WORD_BITS-1:0]             wordSel;
  logic [INDEX_BITS+WORD_BITS-1:0]  slot;
  logic [TAG_BITS-1:0]              wrTag, compTag;
  logic                             assocHit, isTag, isData;
  logic [31:0]                      rdNext;

  assign idx      = busAddr[INDEX_LSB +: INDEX_BITS];
  assign wordSel  = busAddr[2 +: WORD_BITS];
  assign slot     = {idx, wordSel};
  assign wrTag    = busWdata[31:TAG_LSB];
  assign compTag  = strobe.usePhys ? xlatPtag : wrTag;
  assign assocHit = validMem[idx] && (tagMem[idx] == compTag);
  assign isTag    = busAddr[31:24] == REGION_TAG;
  assign isData   = busAddr[31:24] == REGION_DATA;

  always_comb begin
    if (isTag)       rdNext = {tagMem[idx], {(TAG_LSB-1){1'b0}}, validMem[idx]};
    else if (isData) rdNext = dataMem[slot];
    else             rdNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validMem <= '0;
      busRdata <= '0;
      for (int i = 0; i < ENTRIES; i++) tagMem[i] <= '0;
    end else begin
      if (strobe.capRead) busRdata <= rdNext;
      if (strobe.tagWrPlain) begin
        tagMem[idx]   <= wrTag;
        validMem[idx] <= busWdata[0];
      end else if (strobe.tagWrAssoc && assocHit) begin
        validMem[idx] <= busWdata[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) dataMem[i] <= '0;
    end else if (strobe.dataWr) begin
      dataMem[slot] <= busWdata;
    end
  end

endmodule

// File: rtl/icArrayPort.sv
module icArrayPort
  import icArrayPortPkg::*;
#(
  parameter int INDEX_BITS = 8,
  parameter int WORDS      = 8,
  parameter int TAG_BITS   = 22
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [31:0]         busAddr,
  input  logic [1:0]          busSize,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic                busReady,
  input  logic                xlatEnable,
  output logic                xlatReq,
  output logic [TAG_BITS-1:0] xlatVtag,
  input  logic                xlatAck,
  input  logic                xlatHit,
  input  logic                xlatMiss,
  input  logic                xlatMulti,
  input  logic [TAG_BITS-1:0] xlatPtag,
  output logic                faultMultiHit,
  output logic                errSticky
);

  dpStrobe_t strobe;

  assign xlatVtag = busWdata[31 -: TAG_BITS];

  icArrayPortCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .xlatEnable(xlatEnable),
    .xlatAck(xlatAck), .xlatHit(xlatHit), .xlatMiss(xlatMiss),
    .xlatMulti(xlatMulti), .strobe(strobe), .busReady(busReady),
    .xlatReq(xlatReq), .faultMultiHit(faultMultiHit), .errSticky(errSticky)
  );

  icArrayPortDatapath #(
    .INDEX_BITS(INDEX_BITS), .WORDS(WORDS), .TAG_BITS(TAG_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr),
    .busWdata(busWdata), .xlatPtag(xlatPtag), .busRdata(busRdata)
  );

endmodule

// File: rtl/icArrayPortChecker.sv
module icArrayPortChecker (
  input logic        clk,
  input logic        rstN,
  input logic        busValid,
  input logic [31:0] busAddr,
  input logic [1:0]  busSize,
  input logic        busReady,
  input logic        xlatReq,
  input logic        xlatAck,
  input logic        xlatMulti,
  input logic        faultMultiHit,
  input logic        errSticky
);

  a_r11_ready_single: assert property (@(posedge clk) disable iff (!rstN)
    busReady |=> !busReady);

  a_r11_ready_needs_request: assert property (@(posedge clk) disable iff (!rstN)
    busReady |-> $past(busValid));

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky);

  a_r10_err_on_illegal: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady && !xlatReq &&
     ((busSize != 2'b10) || (busAddr[1:0] != 2'b00))) |=> errSticky);

  a_r8_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (xlatReq && !xlatAck) |=> xlatReq);

  a_r9_fault_source: assert property (@(posedge clk) disable iff (!rstN)
    faultMultiHit |-> $past(xlatReq && xlatAck && xlatMulti));

  a_r9_fault_with_ready: assert property (@(posedge clk) disable iff (!rstN)
    faultMultiHit |-> busReady);

endmodule

bind icArrayPort icArrayPortChecker u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busAddr(busAddr),
  .busSize(busSize), .busReady(busReady), .xlatReq(xlatReq),
  .xlatAck(xlatAck), .xlatMulti(xlatMulti),
  .faultMultiHit(faultMultiHit), .errSticky(errSticky)
);

// File: tb/icArrayPort_bench.sv
module icArrayPort_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [31:0] busAddr = '0, busWdata = '0;
  logic [1:0] busSize = 2'b10;
  logic [31:0] busRdata;
  logic busReady, xlatReq, faultMultiHit, errSticky;
  logic xlatEnable = 1'b0, xlatAck = 1'b0, xlatHit = 1'b0, xlatMiss = 1'b0, xlatMulti = 1'b0;
  logic [21:0] xlatVtag, xlatPtag = '0;

  int nChecks = 0, nFails = 0;
  logic [31:0] gotData;
  int gotLat;
  logic gotFault;

  always #5 clk = ~clk;

  icArrayPort u_icArrayPort (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .busReady(busReady), .xlatEnable(xlatEnable),
    .xlatReq(xlatReq), .xlatVtag(xlatVtag), .xlatAck(xlatAck),
    .xlatHit(xlatHit), .xlatMiss(xlatMiss), .xlatMulti(xlatMulti),
    .xlatPtag(xlatPtag), .faultMultiHit(faultMultiHit), .errSticky(errSticky)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [31:0] addr,
                        input logic [31:0] wdata, input logic [1:0] size);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = addr; busWdata = wdata; busSize = size;
    gotLat = 0;
    do begin
      @(negedge clk);
      gotLat++;
    end while (!busReady && gotLat < 200);
    gotData  = busRdata;
    gotFault = faultMultiHit;
    busValid = 1'b0;
  endtask

  task automatic respond(input int delay, input logic hit, input logic miss,
                         input logic multi, input logic [21:0] ptag,
                         input logic [21:0] expVtag);
    int w = 0;
    do begin
      @(negedge clk);
      w++;
    end while (!xlatReq && w < 200);
    check("R8 vtag", {10'd0, xlatVtag}, {10'd0, expVtag});
    repeat (delay) @(negedge clk);
    xlatAck = 1'b1; xlatHit = hit; xlatMiss = miss; xlatMulti = multi; xlatPtag = ptag;
    @(negedge clk);
    xlatAck = 1'b0; xlatHit = 1'b0; xlatMiss = 1'b0; xlatMulti = 1'b0;
  endtask

  task automatic xlatWrite(input logic [31:0] addr, input logic [31:0] wdata,
                           input logic hit, input logic miss, input logic multi,
                           input logic [21:0] ptag);
    fork
      access(1'b1, addr, wdata, 2'b10);
      respond(3, hit, miss, multi, ptag, wdata[31:10]);
    join
  endtask

  localparam int NV = 18;
  localparam logic        vWr   [NV] = '{1,0,0,1,1,0,0,0,1,0,0,1,0,1,0,1,0,0};
  localparam logic [31:0] vAddr [NV] = '{
    32'hF000_0020, 32'hF000_0020, 32'hF000_0040, 32'hF100_0024, 32'hF100_0028,
    32'hF100_0024, 32'hF100_0028, 32'hF100_1FE4, 32'hF000_1FE0, 32'hF000_1FE0,
    32'hF000_2020, 32'hF000_0028, 32'hF000_0020, 32'hF000_0028, 32'hF000_0020,
    32'hF200_0020, 32'hF200_0020, 32'hF100_0020};
  localparam logic [31:0] vData [NV] = '{
    32'h048D_17FF, 32'h048D_1401, 32'h0000_0000, 32'hCAFE_F00D, 32'h1111_2222,
    32'hCAFE_F00D, 32'h1111_2222, 32'h0000_0000, 32'hFFFF_FC01, 32'hFFFF_FC01,
    32'h048D_1401, 32'h048D_1800, 32'h048D_1401, 32'h048D_1400, 32'h048D_1400,
    32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000};
  localparam string vReq [NV] = '{
    "R6 plain write", "R5 R6 tag readback", "R3 other entry", "R4 data write",
    "R4 data write", "R4 word1", "R4 word2", "R3 last entry data",
    "R6 write last entry", "R3 last entry tag", "R3 upper bits ignored",
    "R7 assoc mismatch", "R7 mismatch no change", "R7 assoc match",
    "R7 valid cleared", "R2 other region write", "R2 other region read",
    "R4 word0 untouched"};

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready", {31'd0, busReady}, 32'd0);
    check("R1 req", {31'd0, xlatReq}, 32'd0);
    check("R1 fault", {31'd0, faultMultiHit}, 32'd0);
    check("R1 err", {31'd0, errSticky}, 32'd0);
    rstN = 1'b1;
    access(1'b0, 32'hF000_00A0, 32'd0, 2'b10);
    check("R1 tag after reset", gotData, 32'd0);

    for (int i = 0; i < NV; i++) begin
      access(vWr[i], vAddr[i], vData[i], 2'b10);
      check("R11 latency", gotLat, 32'd1);
      if (!vWr[i]) check(vReq[i], gotData, vData[i]);
    end
    access(1'b1, 32'hF000_0028, 32'h048D_1401, 2'b10);
    access(1'b0, 32'hF000_0020, 32'd0, 2'b10);
    check("R7 stored invalid stays", gotData, 32'h048D_1400);
    access(1'b0, 32'hF000_0020, 32'd0, 2'b10);
    check("R2 tag region untouched", gotData, 32'h048D_1400);

    xlatEnable = 1'b1;
    access(1'b1, 32'hF000_00A0, 32'h002A_F001, 2'b10);
    xlatWrite(32'hF000_00A8, 32'h0444_4400, 1'b1, 1'b0, 1'b0, 22'h00ABD);
    check("R8 latency", gotLat, 32'd5);
    access(1'b0, 32'hF000_00A0, 32'd0, 2'b10);
    check("R8 ptag mismatch", gotData, 32'h002A_F001);
    xlatWrite(32'hF000_00A8, 32'h0444_4400, 1'b0, 1'b1, 1'b0, 22'h00ABC);
    access(1'b0, 32'hF000_00A0, 32'd0, 2'b10);
    check("R8 miss no-op", gotData, 32'h002A_F001);
    xlatWrite(32'hF000_00A8, 32'h0444_4400, 1'b0, 1'b0, 1'b1, 22'h00ABC);
    check("R9 fault pulse", {31'd0, gotFault}, 32'd1);
    @(negedge clk);
    check("R9 fault single", {31'd0, faultMultiHit}, 32'd0);
    access(1'b0, 32'hF000_00A0, 32'd0, 2'b10);
    check("R9 no write", gotData, 32'h002A_F001);
    xlatWrite(32'hF000_00A8, 32'h0444_4400, 1'b1, 1'b0, 1'b0, 22'h00ABC);
    check("R9 no fault on hit", {31'd0, gotFault}, 32'd0);
    access(1'b0, 32'hF000_00A0, 32'd0, 2'b10);
    check("R8 physical match", gotData, 32'h002A_F000);
    xlatEnable = 1'b0;

    check("R10 err clear", {31'd0, errSticky}, 32'd0);
    access(1'b1, 32'hF000_00A0, 32'h0000_0001, 2'b00);
    check("R10 ready on illegal", gotLat, 32'd1);
    check("R10 err set", {31'd0, errSticky}, 32'd1);
    access(1'b1, 32'hF100_00A2, 32'h5555_5555, 2'b10);
    access(1'b0, 32'hF000_00A0, 32'd0, 2'b10);
    check("R10 byte ignored", gotData, 32'h002A_F000);
    access(1'b0, 32'hF100_00A0, 32'd0, 2'b10);
    check("R10 misaligned ignored", gotData, 32'd0);
    check("R10 err holds", {31'd0, errSticky}, 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule